// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps one address reservation for one hardware thread so that a core can build atomic read-modify-write sequences from a reserving load followed by a conditional store. Each cycle the core pipeline reports at most one memory operation: a reserving load, a conditional store, an ordinary store, or any other access. Alongside it, the pipeline can flag an exception entry, and the memory system can report a store made by another master through a snoop port. The monitor keeps the reserved word address and a valid flag. It decides in the same cycle whether a conditional store may write. The memory write enable it drives is suppressed when the store fails. One cycle later it strobes a one-bit success value toward the register file.

The result is written into the register named by the store's data-source field. The monitor passes that register index through with the result. Events arrive as single-cycle strobes and no back-pressure exists: the monitor takes one core operation and one snoop report in every cycle, so there is no ready signal on either input. Operation codes on `op_kind` are 0 = other access (no effect), 1 = reserving load, 2 = conditional store, 3 = ordinary store.

Top module: `lrsc_monitor`

## Requirements
- R1: A reserving load (`op_kind` 1) records the word address `op_addr[ADDR_W-1:2]` and makes the reservation valid. Address bits [1:0] take no part in any comparison.
- R2: A conditional store (`op_kind` 2) passes (`sc_pass` = 1 in the same cycle) only when the reservation is valid and its word address equals the reserved word.
- R3: `mem_we_gated` is 1 in the cycle of a passing conditional store and 0 in the cycle of a failing one. It is 1 for every ordinary store (`op_kind` 3) and 0 for reserving loads and other accesses.
- R4: In the cycle after each conditional store, and only then, `result_valid` is 1 for one cycle. In that cycle `result_reg` equals that store's `op_src_reg` and `result_data` is 1 for pass and 0 for fail.
- R5: An ordinary store to the reserved word clears the reservation. An ordinary store to another word leaves it intact.
- R6: Every conditional store clears the reservation once evaluated, whatever its address or outcome.
- R7: A later reserving load replaces the reserved address, so only the newest address can pass.
- R8: `exc_entry` clears the reservation.
- R9: A snoop report (`snoop_valid`) whose word address matches the reserved word clears the reservation. A snoop to another word leaves it intact.
- R10: When a reserving load coincides with `exc_entry` or a matching snoop, the new reservation wins and is valid afterwards.
- R11: After reset no reservation exists, so any conditional store fails and `result_valid` is 0.
- R12: A conditional store in the same cycle as `exc_entry` or a snoop to the reserved word fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A core memory operation is present this cycle |
| op_kind | input | 2 | 0 other, 1 reserving load, 2 conditional store, 3 ordinary store |
| op_addr | input | ADDR_W | Byte address of the operation |
| op_src_reg | input | REG_W | Data-source register index of the operation |
| exc_entry | input | 1 | Exception or trap entry this cycle |
| snoop_valid | input | 1 | Another master stores this cycle |
| snoop_addr | input | ADDR_W | Byte address of the snooped store |
| sc_pass | output | 1 | Current conditional store succeeds |
| mem_we_gated | output | 1 | Memory write enable after gating |
| result_valid | output | 1 | Success value write-back strobe |
| result_reg | output | REG_W | Register receiving the success value |
| result_data | output | 1 | 1 on success, 0 on failure |

## Verification
The bench builds the monitor with a 6-bit address and a 3-bit register index. With those widths, every reserved byte address can be paired with every conditional-store byte address: all 4096 pairs are tried, which covers the ignored low bits and every word match and mismatch. The narrow register index lets the bench vary the source field across all eight values during the sweep. Directed sequences then cover each clearing event, relinking, the same-cycle races, and reset.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OPK_OTHER = 2'd0,
    OPK_LR    = 2'd1,
    OPK_SC    = 2'd2,
    OPK_ST    = 2'd3
  } op_kind_e;
endpackage

// File: rtl/lrsc_word_cmp.sv
module lrsc_word_cmp #(
  parameter int TAG_W = 30
) (
  input  logic             probe_en,
  input  logic [TAG_W-1:0] probe_tag,
  input  logic             link_valid,
  input  logic [TAG_W-1:0] link_tag,
  output logic             hit
);
  always_comb hit = probe_en && link_valid && (probe_tag == link_tag);
endmodule

// File: rtl/lrsc_link_reg.sv
module lrsc_link_reg #(
  parameter int TAG_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             drop_en,
  output logic             link_valid,
  output logic [TAG_W-1:0] link_tag
);
  // a new reservation outranks any drop in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_tag   <= '0;
    end else if (set_en) begin
      link_valid <= 1'b1;
      link_tag   <= set_tag;
    end else if (drop_en) begin
      link_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lrsc_result_stage.sv
module lrsc_result_stage #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             pass,
  input  logic [REG_W-1:0] src_reg,
  output logic             result_valid,
  output logic [REG_W-1:0] result_reg,
  output logic             result_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      result_reg   <= '0;
      result_data  <= 1'b0;
    end else begin
      result_valid <= fire;
      if (fire) begin
        result_reg  <= src_reg;
        result_data <= pass;
      end
    end
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int ADDR_W    = 32,
  parameter int REG_W     = 5,
  parameter int GRAIN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [REG_W-1:0]  op_src_reg,
  input  logic              exc_entry,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              sc_pass,
  output logic              mem_we_gated,
  output logic              result_valid,
  output logic [REG_W-1:0]  result_reg,
  output logic              result_data
);
  import lrsc_pkg::*;

  localparam int TAG_W = ADDR_W - GRAIN_LSB;
  localparam int NPROBE = 2; // 0: core operation, 1: snoop

  op_kind_e   kind;
  logic       is_lr, is_sc, is_st;
  logic       link_valid;
  logic [TAG_W-1:0] link_tag;
  logic [NPROBE-1:0] probe_en;
  logic [NPROBE-1:0][TAG_W-1:0] probe_tag;
  logic [NPROBE-1:0] probe_hit;
  logic       race_kill, drop_en;

  always_comb begin
    kind  = op_kind_e'(op_kind);
    is_lr = op_valid && (kind == OPK_LR);
    is_sc = op_valid && (kind == OPK_SC);
    is_st = op_valid && (kind == OPK_ST);
    probe_en[0]  = op_valid;
    probe_tag[0] = op_addr[ADDR_W-1:GRAIN_LSB];
    probe_en[1]  = snoop_valid;
    probe_tag[1] = snoop_addr[ADDR_W-1:GRAIN_LSB];
  end

  for (genvar g = 0; g < NPROBE; g++) begin : g_probe
    lrsc_word_cmp #(.TAG_W(TAG_W)) u_cmp (
      .probe_en  (probe_en[g]),
      .probe_tag (probe_tag[g]),
      .link_valid(link_valid),
      .link_tag  (link_tag),
      .hit       (probe_hit[g])
    );
  end

  always_comb begin
    race_kill    = exc_entry || probe_hit[1];
    sc_pass      = is_sc && probe_hit[0] && !race_kill;
    mem_we_gated = is_st || sc_pass;
    drop_en      = exc_entry || probe_hit[1] || is_sc || (is_st && probe_hit[0]);
  end

  lrsc_link_reg #(.TAG_W(TAG_W)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (is_lr),
    .set_tag   (probe_tag[0]),
    .drop_en   (drop_en),
    .link_valid(link_valid),
    .link_tag  (link_tag)
  );

  lrsc_result_stage #(.REG_W(REG_W)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (is_sc),
    .pass        (sc_pass),
    .src_reg     (op_src_reg),
    .result_valid(result_valid),
    .result_reg  (result_reg),
    .result_data (result_data)
  );
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_kind,
  input logic [REG_W-1:0] op_src_reg,
  input logic             exc_entry,
  input logic             sc_pass,
  input logic             mem_we_gated,
  input logic             result_valid,
  input logic [REG_W-1:0] result_reg,
  input logic             result_data
);
  logic sc_now, lr_now, st_now;
  always_comb begin
    sc_now = op_valid && (op_kind == 2'd2);
    lr_now = op_valid && (op_kind == 2'd1);
    st_now = op_valid && (op_kind == 2'd3);
  end

  p_pass_only_on_sc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> sc_now);
  p_fail_blocks_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_now && !sc_pass) |-> !mem_we_gated);
  p_plain_store_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_now |-> mem_we_gated);
  p_result_follows_sc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_now |=> (result_valid && result_data == $past(sc_pass) && result_reg == $past(op_src_reg)));
  p_no_stray_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_now |=> !result_valid);
  p_sc_consumes_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sc_now |=> !sc_pass);
  p_exc_drops_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && !lr_now) |=> !sc_pass);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .op_src_reg(op_src_reg), .exc_entry(exc_entry), .sc_pass(sc_pass),
  .mem_we_gated(mem_we_gated), .result_valid(result_valid),
  .result_reg(result_reg), .result_data(result_data)
);

// File: tb/lrsc_monitor_test.sv
`timescale 1ns/1ps
module lrsc_monitor_test;
  localparam int AW = 6;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0;
  logic [RW-1:0] op_src_reg = '0;
  logic exc_entry = 1'b0;
  logic snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic sc_pass, mem_we_gated, result_valid, result_data;
  logic [RW-1:0] result_reg;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lrsc_monitor #(.ADDR_W(AW), .REG_W(RW), .GRAIN_LSB(2)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_src_reg(op_src_reg), .exc_entry(exc_entry),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .sc_pass(sc_pass),
    .mem_we_gated(mem_we_gated), .result_valid(result_valid),
    .result_reg(result_reg), .result_data(result_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 1'b0; op_kind = 2'd0; exc_entry = 1'b0; snoop_valid = 1'b0;
  endtask

  // one cycle of stimulus; held until the next task call's negedge
  task automatic issue(input int kind, input int addr, input bit exc,
                       input bit sv, input int sa);
    @(negedge clk);
    idle_inputs();
    op_valid = (kind >= 0);
    op_kind = (kind >= 0) ? 2'(kind) : 2'd0;
    op_addr = AW'(addr);
    exc_entry = exc;
    snoop_valid = sv;
    snoop_addr = AW'(sa);
    #1;
    if (kind == 3) chk(mem_we_gated == 1'b1, "R3 store we", int'(mem_we_gated), 1);
    if (kind == 1) chk(mem_we_gated == 1'b0, "R3 load we", int'(mem_we_gated), 0);
  endtask

  // conditional store; checks same-cycle gating and next-cycle result
  task automatic sc_probe(input int addr, input int src, input bit exp,
                          input bit exc, input bit sv, input int sa, input string req);
    @(negedge clk);
    idle_inputs();
    op_valid = 1'b1; op_kind = 2'd2; op_addr = AW'(addr); op_src_reg = RW'(src);
    exc_entry = exc; snoop_valid = sv; snoop_addr = AW'(sa);
    #1;
    chk(sc_pass == exp, {req, " R2 pass"}, int'(sc_pass), int'(exp));
    chk(mem_we_gated == exp, {req, " R3 gated we"}, int'(mem_we_gated), int'(exp));
    @(negedge clk);
    idle_inputs();
    chk(result_valid == 1'b1, {req, " R4 strobe"}, int'(result_valid), 1);
    chk(result_data == exp, {req, " R4 data"}, int'(result_data), int'(exp));
    chk(int'(result_reg) == (src % 8), {req, " R4 reg"}, int'(result_reg), src % 8);
    #1;
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    // R11: reset state, conditional store during and after reset fails
    repeat (2) @(negedge clk);
    chk(result_valid == 1'b0, "R11 reset strobe", int'(result_valid), 0);
    op_valid = 1'b1; op_kind = 2'd2; op_addr = '0; #1;
    chk(sc_pass == 1'b0, "R11 pass in reset", int'(sc_pass), 0);
    @(negedge clk);
    idle_inputs();
    chk(result_valid == 1'b0, "R11 no strobe in reset", int'(result_valid), 0);
    rst_n = 1'b1;
    sc_probe(0, 1, 1'b0, 1'b0, 1'b0, 0, "R11 after reset");

    // R1 R2 R3 R4 R6: every reserved address against every store address
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        issue(1, a, 1'b0, 1'b0, 0);
        sc_probe(b, a + b, ((a >> 2) == (b >> 2)), 1'b0, 1'b0, 0, "R1 sweep");
      end
    end
    // R4: no strobe without a conditional store
    issue(0, 5, 1'b0, 1'b0, 0);
    @(negedge clk); idle_inputs();
    chk(result_valid == 1'b0, "R4 idle strobe", int'(result_valid), 0);

    // R6: passing store consumes the link; failing store to another word too
    issue(1, 8, 1'b0, 1'b0, 0);
    sc_probe(8, 2, 1'b1, 1'b0, 1'b0, 0, "R6 first");
    sc_probe(8, 3, 1'b0, 1'b0, 1'b0, 0, "R6 second");
    issue(1, 8, 1'b0, 1'b0, 0);
    sc_probe(20, 4, 1'b0, 1'b0, 1'b0, 0, "R6 other word");
    sc_probe(8, 5, 1'b0, 1'b0, 1'b0, 0, "R6 after other");

    // R5: ordinary store, same word clears, other word keeps
    issue(1, 12, 1'b0, 1'b0, 0);
    issue(3, 15, 1'b0, 1'b0, 0);
    sc_probe(12, 1, 1'b0, 1'b0, 1'b0, 0, "R5 same word");
    issue(1, 12, 1'b0, 1'b0, 0);
    issue(3, 16, 1'b0, 1'b0, 0);
    sc_probe(13, 1, 1'b1, 1'b0, 1'b0, 0, "R5 other word");

    // R7: relink
    issue(1, 24, 1'b0, 1'b0, 0);
    issue(1, 40, 1'b0, 1'b0, 0);
    sc_probe(24, 6, 1'b0, 1'b0, 1'b0, 0, "R7 old addr");
    issue(1, 24, 1'b0, 1'b0, 0);
    issue(1, 40, 1'b0, 1'b0, 0);
    sc_probe(42, 7, 1'b1, 1'b0, 1'b0, 0, "R7 new addr");

    // R8: exception entry
    issue(1, 32, 1'b0, 1'b0, 0);
    issue(-1, 0, 1'b1, 1'b0, 0);
    sc_probe(32, 0, 1'b0, 1'b0, 1'b0, 0, "R8 exception");

    // R9: snoop same word and other word
    issue(1, 48, 1'b0, 1'b0, 0);
    issue(-1, 0, 1'b0, 1'b1, 51);
    sc_probe(48, 1, 1'b0, 1'b0, 1'b0, 0, "R9 snoop hit");
    issue(1, 48, 1'b0, 1'b0, 0);
    issue(-1, 0, 1'b0, 1'b1, 52);
    sc_probe(48, 1, 1'b1, 1'b0, 1'b0, 0, "R9 snoop miss");

    // R10: new reservation beats simultaneous clear
    issue(1, 4, 1'b0, 1'b0, 0);
    issue(1, 56, 1'b1, 1'b0, 0);
    sc_probe(56, 2, 1'b1, 1'b0, 1'b0, 0, "R10 with exception");
    issue(1, 56, 1'b0, 1'b0, 0);
    issue(1, 56, 1'b0, 1'b1, 57);
    sc_probe(58, 3, 1'b1, 1'b0, 1'b0, 0, "R10 with snoop");

    // R12: same-cycle race kills the store
    issue(1, 36, 1'b0, 1'b0, 0);
    sc_probe(36, 4, 1'b0, 1'b1, 1'b0, 0, "R12 exception");
    issue(1, 36, 1'b0, 1'b0, 0);
    sc_probe(36, 5, 1'b0, 1'b0, 1'b1, 39, "R12 snoop hit");
    issue(1, 36, 1'b0, 1'b0, 0);
    sc_probe(36, 6, 1'b1, 1'b0, 1'b1, 40, "R12 snoop miss");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule